// File: doc/BRIEF.md
# Shared-Multiplier First-Order Recursive Filter

This block applies the recursion x[k] = a·x[k-1] + b·u[k] to a stream of signed fixed-point samples. The datapath has one physical multiplier. Operand multiplexers give it (b, u) in one control state and (a, x) in the next. A holding register keeps the first truncated product. A saturating adder combines that held product with the live multiplier output. The result is written back into the state register, which supplies x[k-1] for the next sample.

A four-state controller runs the schedule: wait, multiply b·u, multiply a·x and add, present the result. A sample is accepted through a valid/ready handshake. The filtered value appears on a valid-qualified output for one cycle. Both coefficients are static inputs and are captured together with the sample, so later changes on them cannot disturb a computation that is already running.

Top module: `iir1_shared`

## Requirements
- R1: While rst_n is low the state x is forced to zero, so out_data reads 0. in_ready reads 1 and out_valid reads 0. After reset the first output equals trunc(b·u).
- R2: A sample is accepted on a rising clock edge where in_valid and in_ready are both 1. in_ready is 1 only while the controller waits for input, and it drops to 0 in the cycle after an acceptance.
- R3: Each accepted sample gives the new state x = sat(trunc(b·u) + trunc(a·x_prev)). All values are 16-bit two's complement Q1.15. trunc is the 32-bit product shifted arithmetically right by 15 bits, kept as 17 bits. The new x becomes x_prev for the next sample.
- R4: When the 18-bit sum exceeds 32767, the result is 0x7FFF. When the sum is below -32768, the result is 0x8000.
- R5: out_valid is 1 for exactly one cycle. That cycle is the third cycle after the acceptance edge, and out_data then holds the new x. in_ready returns to 1 in the cycle after that.
- R6: in_valid and in_data are ignored while the controller is busy. out_data changes only when the value becomes valid.
- R7: coef_a and coef_b are captured at the acceptance edge. Changing them during the computation does not alter that sample's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 16 | Input sample u, Q1.15 |
| coef_a | input | 16 | Feedback coefficient a, Q1.15 |
| coef_b | input | 16 | Input coefficient b, Q1.15 |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 16 | Current state x, Q1.15 |

## Verification
Some properties are checked by assertions on every cycle:
- the three-cycle spacing from acceptance to the output strobe;
- the single-cycle width of that strobe;
- in_ready being low while busy and never high together with out_valid;
- out_data changing only on a valid cycle;
- the cleared state during reset.

The numerical result cannot be checked by a property: the correct recursion, the truncation and both saturation limits need the bench's reference model running over random and directed sample sequences. The same holds for the capture of the coefficients at acceptance and the clean restart after a reset in the middle of a run. The bench shows these by changing the coefficients and in_data while the block is busy, and by comparing each output with the model.

// File: rtl/iir1_pkg.sv
package iir1_pkg;
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_MUL_BU     = 2'd1,
        ST_MUL_AX_ADD = 2'd2,
        ST_OUT        = 2'd3
    } iir1_state_e;
endpackage

// File: rtl/iir1_ctrl.sv
module iir1_ctrl
    import iir1_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output iir1_state_e state_o,
    output logic        ready_o
);
    iir1_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:       if (in_valid) st_d = ST_MUL_BU;
            ST_MUL_BU:     st_d = ST_MUL_AX_ADD;
            ST_MUL_AX_ADD: st_d = ST_OUT;
            ST_OUT:        st_d = ST_IDLE;
            default:       st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign state_o = st_q;
    assign ready_o = (st_q == ST_IDLE);
endmodule

// File: rtl/iir1_mul.sv
module iir1_mul #(
    parameter int W    = 16,
    parameter int FRAC = 15
) (
    input  logic                sel_ax,
    input  logic signed [W-1:0] coef_a,
    input  logic signed [W-1:0] coef_b,
    input  logic signed [W-1:0] samp_u,
    input  logic signed [W-1:0] state_x,
    output logic signed [W:0]   prod_t
);
    localparam int PW = 2 * W;

    logic signed [W-1:0]  opa, opb;
    logic signed [PW-1:0] prod;

    always_comb begin
        opa = sel_ax ? coef_a  : coef_b;
        opb = sel_ax ? state_x : samp_u;
    end

    assign prod   = opa * opb;
    assign prod_t = (W+1)'(prod >>> FRAC);
endmodule

// File: rtl/iir1_sat_add.sv
module iir1_sat_add #(
    parameter int W = 16
) (
    input  logic signed [W:0]   p0,
    input  logic signed [W:0]   p1,
    output logic signed [W-1:0] y
);
    localparam logic signed [W+1:0] HI = $signed({3'b000, {(W-1){1'b1}}});
    localparam logic signed [W+1:0] LO = $signed({3'b111, {(W-1){1'b0}}});

    logic signed [W+1:0] sum;

    always_comb begin
        sum = (W+2)'(p0) + (W+2)'(p1);
        if (sum > HI)      y = HI[W-1:0];
        else if (sum < LO) y = LO[W-1:0];
        else               y = sum[W-1:0];
    end
endmodule

// File: rtl/iir1_shared.sv
module iir1_shared
    import iir1_pkg::*;
#(
    parameter int W    = 16,
    parameter int FRAC = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic signed [W-1:0] in_data,
    input  logic signed [W-1:0] coef_a,
    input  logic signed [W-1:0] coef_b,
    output logic                out_valid,
    output logic signed [W-1:0] out_data
);
    typedef struct packed {
        logic signed [W-1:0] u;
        logic signed [W-1:0] a;
        logic signed [W-1:0] b;
        logic signed [W-1:0] x;
        logic signed [W:0]   hold;
    } dp_t;

    dp_t                 dp_d, dp_q;
    iir1_state_e         state;
    logic                accept;
    logic signed [W:0]   prod_t;
    logic signed [W-1:0] sum_sat;

    iir1_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .state_o  (state),
        .ready_o  (in_ready)
    );

    iir1_mul #(.W(W), .FRAC(FRAC)) u_mul (
        .sel_ax  (state == ST_MUL_AX_ADD),
        .coef_a  (dp_q.a),
        .coef_b  (dp_q.b),
        .samp_u  (dp_q.u),
        .state_x (dp_q.x),
        .prod_t  (prod_t)
    );

    iir1_sat_add #(.W(W)) u_add (
        .p0 (dp_q.hold),
        .p1 (prod_t),
        .y  (sum_sat)
    );

    assign accept = in_valid && in_ready;

    always_comb begin
        dp_d = dp_q;
        if (accept) begin
            dp_d.u = in_data;
            dp_d.a = coef_a;
            dp_d.b = coef_b;
        end
        if (state == ST_MUL_BU)     dp_d.hold = prod_t;
        if (state == ST_MUL_AX_ADD) dp_d.x    = sum_sat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign out_valid = (state == ST_OUT);
    assign out_data  = dp_q.x;
endmodule

// File: rtl/iir1_shared_chk.sv
module iir1_shared_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_ready,
    input logic         out_valid,
    input logic [W-1:0] out_data
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (out_data == '0 && !out_valid && in_ready)); // R1

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R2

    AST_READY_OUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid)); // R2

    AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ##2 out_valid); // R5

    AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R5

    AST_OUT_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_data) |-> out_valid); // R6
endmodule

bind iir1_shared iir1_shared_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/iir1_shared_tb.sv
`timescale 1ns/1ps
module iir1_shared_tb;
    localparam int W = 16;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic                in_ready;
    logic signed [W-1:0] in_data = '0;
    logic signed [W-1:0] coef_a = '0;
    logic signed [W-1:0] coef_b = '0;
    logic                out_valid;
    logic signed [W-1:0] out_data;

    int checks = 0;
    int fails  = 0;
    logic signed [W-1:0] model_x = '0;

    always #10 clk = ~clk;

    iir1_shared #(.W(W), .FRAC(15)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .coef_a(coef_a), .coef_b(coef_b),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic signed [W-1:0] ref_step(
        logic signed [W-1:0] x, logic signed [W-1:0] u,
        logic signed [W-1:0] a, logic signed [W-1:0] b);
        longint p1, p2, s;
        p1 = (longint'(b) * longint'(u)) >>> 15;
        p2 = (longint'(a) * longint'(x)) >>> 15;
        s  = p1 + p2;
        if (s > 32767)       s = 32767;
        else if (s < -32768) s = -32768;
        return W'(s);
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Entered at a negedge with the controller idle; leaves at a negedge, idle again.
    task automatic run_sample(logic signed [W-1:0] u, logic signed [W-1:0] a,
                              logic signed [W-1:0] b, bit noise);
        logic signed [W-1:0] exp_x;
        exp_x = ref_step(model_x, u, a, b);
        chk(in_ready == 1'b1, "R2 ready when idle", in_ready, 1);
        in_valid = 1'b1; in_data = u; coef_a = a; coef_b = b;
        @(negedge clk);
        chk(in_ready == 1'b0, "R2 not ready after accept", in_ready, 0);
        chk(out_valid == 1'b0, "R5 no early valid", out_valid, 0);
        // R7 and R6: disturb coefficients and offer a new sample while busy
        in_valid = noise;
        in_data  = W'($urandom);
        coef_a   = W'($urandom);
        coef_b   = W'($urandom);
        @(negedge clk);
        chk(out_valid == 1'b0, "R5 no valid in second busy cycle", out_valid, 0);
        chk(out_data == model_x, "R6 output held while busy", out_data, model_x);
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b1, "R5 valid on third cycle", out_valid, 1);
        chk(out_data == exp_x, "R3 R4 R7 filtered value", out_data, exp_x);
        model_x = exp_x;
        @(negedge clk);
        chk(out_valid == 1'b0, "R5 valid lasts one cycle", out_valid, 0);
        chk(in_ready == 1'b1, "R5 ready returns", in_ready, 1);
        chk(out_data == model_x, "R6 value holds", out_data, model_x);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(out_data == '0, "R1 state cleared", out_data, 0);
        chk(in_ready == 1'b1, "R1 ready in reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1 no valid in reset", out_valid, 0);
        rst_n = 1'b1;
        model_x = '0;
        @(negedge clk);
    endtask

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1: first output after reset depends only on b*u
        run_sample(16'sd16384, 16'sd32767, 16'sd16384, 1'b0);
        // R4: positive saturation
        run_sample(16'sd32767, 16'sd32767, 16'sd32767, 1'b1);
        run_sample(16'sd32767, 16'sd32767, 16'sd32767, 1'b0);
        // R4: negative saturation
        run_sample(-16'sd32768, 16'sd32767, 16'sd32767, 1'b1);
        run_sample(-16'sd32768, 16'sd32767, 16'sd32767, 1'b0);
        // R3: -1 * -1 product truncates to +32768 before the sum
        run_sample(-16'sd32768, 16'sd0, -16'sd32768, 1'b0);
        // R3: negative products round toward minus infinity
        run_sample(-16'sd3, 16'sd0, 16'sd1, 1'b1);
        // R3: recursion with decay
        for (int i = 0; i < 40; i++)
            run_sample(W'($urandom), 16'sd29491, 16'sd3277, 1'($urandom));
        // R1: reset in the middle of a run clears the state
        do_reset();
        run_sample(16'sd1000, 16'sd20000, 16'sd32767, 1'b0);
        // R3 R4 R7: fully random operands
        for (int i = 0; i < 300; i++)
            run_sample(W'($urandom), W'($urandom), W'($urandom), 1'($urandom));
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule